// File: doc/BRIEF.md
# Macroblock ROI QP Map Generator

The block builds a per-macroblock quantiser control map inside an on-chip memory that an encoder's rate control reads. The frame is divided into 16x16 macroblocks, and each map word tells the encoder four things about one macroblock: whether to force intra coding, which area class it belongs to, and a QP adjustment that is either absolute or relative to the frame QP.

Before a frame, software loads rectangular regions, given in pixels, into numbered slots. It then pulses `start` with the frame size and the number of slots to use. The block first resets the whole padded map area to a neutral word. It then checks every active region in a single cycle. If all of them are acceptable, it paints them one macroblock per clock in slot order, so a later slot overwrites an earlier one where they overlap. `done` pulses once when the job is over, and `error` reports a rejected job. A rejected job leaves the map in its neutral state.

Top module: `roi_map_gen`

## Requirements
- R1: After reset, `done`, `error` and `busy` are 0.
- R2: Column count is ceil(width/16) and row count is ceil(height/16). The row stride is the column count rounded up to a multiple of 4, and macroblock (mx,my) lives at address my*stride+mx.
- R3: Every job with a legal frame size first writes the neutral word 0x010 (area enable set, every other field zero) to addresses 0 through stride*rows4-1, where rows4 is the row count rounded up to a multiple of 4.
- R4: A region covers columns floor(x/16) up to floor(x/16)+ceil(w/16)-1, clipped to the column count. Rows are formed the same way from y and h. A region with zero extent writes nothing.
- R5: A painted word is laid out as bit 0 force-intra, bits 3:1 area index, bit 4 area enable (always 1), bits 11:5 QP (7-bit two's complement), and bit 12 mode (1 = absolute).
- R6: Regions are painted in ascending slot order, and the later slot wins on overlap.
- R7: A job is rejected when any active slot has x+w > width or y+h > height. Slots at or above the count are not examined.
- R8: A job is rejected when an active slot has a force-intra or mode input above 1, or an area index of 8 or more (the slot count).
- R9: A job is rejected when an active slot's QP lies outside 0..51 in absolute mode, or outside -51..51 in relative mode.
- R10: A job is rejected when the count exceeds 8. A rejected job (R7 to R10) still performs the reset pass of R3, paints nothing, and raises `error`.
- R11: A frame width or height that is zero, negative, or larger than the map capacity (128 pixels by default) rejects the job with no memory write at all. `done` and `error` rise in the cycle right after `start` is sampled.
- R12: Map words are written one per clock in row-major order within a region. A single setup cycle precedes each region and a single check cycle follows the reset pass. `done` is high for exactly one cycle, the one after the last write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Write one region slot (ignored while busy) |
| ld_slot | input | 3 | Slot number to write |
| ld_x | input | 12 | Region left edge in pixels |
| ld_y | input | 12 | Region top edge in pixels |
| ld_w | input | 12 | Region width in pixels |
| ld_h | input | 12 | Region height in pixels |
| ld_intra | input | 2 | Force-intra flag (legal 0..1) |
| ld_mode | input | 2 | QP mode, 1 = absolute (legal 0..1) |
| ld_area | input | 4 | Area index (legal 0..7) |
| ld_qp | input | 8 | Signed QP value |
| start | input | 1 | Begin a job (sampled while idle) |
| frame_w | input | 12 | Signed frame width in pixels |
| frame_h | input | 12 | Signed frame height in pixels |
| region_cnt | input | 5 | Number of slots to apply |
| rd_addr | input | 6 | Map read address |
| rd_data | output | 13 | Map word, one cycle after rd_addr |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle job completion pulse |
| error | output | 1 | Last job rejected; held until next start |

## Verification
Counting from the edge that samples `start`, `done` is due N+1+sum(1+area_i) edges later on an accepted job, where N is stride*rows4. It is due N+1 edges later on a job rejected by region checks, and at the very next edge for an illegal frame size. The bench computes this number for every job and counts falling edges until `done` appears, so any extra or missing write cycle is caught. `error` is sampled in the `done` cycle, and `done` is checked low one cycle later. The map is read back through the registered read port, with the address set on one falling edge and the data sampled on the next.

// File: rtl/roi_map_pkg.sv
package roi_map_pkg;
  localparam int PIX_W      = 12;
  localparam int AREA_IDX_W = 3;
  localparam int AREA_IN_W  = AREA_IDX_W + 1;
  localparam int FLAG_W     = 2;
  localparam int QP_W       = 7;
  localparam int QP_IN_W    = 8;

  typedef struct packed {
    logic                  mode;
    logic [QP_W-1:0]       qp;
    logic                  area_en;
    logic [AREA_IDX_W-1:0] area_idx;
    logic                  force_intra;
  } map_word_t;

  typedef struct packed {
    logic [PIX_W-1:0]     x;
    logic [PIX_W-1:0]     y;
    logic [PIX_W-1:0]     w;
    logic [PIX_W-1:0]     h;
    logic [FLAG_W-1:0]    intra;
    logic [FLAG_W-1:0]    mode;
    logic [AREA_IN_W-1:0] area;
    logic [QP_IN_W-1:0]   qp;
  } region_t;

  localparam map_word_t WORD_NEUTRAL = '{mode: 1'b0, qp: '0, area_en: 1'b1,
                                         area_idx: '0, force_intra: 1'b0};
endpackage

// File: rtl/roi_region_check.sv
module roi_region_check
  import roi_map_pkg::*;
#(
  parameter int MAX_REGIONS = 8,
  parameter int MB_W        = 4
) (
  input  region_t          rg,
  input  logic [PIX_W-1:0] fw,
  input  logic [PIX_W-1:0] fh,
  input  logic [MB_W-1:0]  cols,
  input  logic [MB_W-1:0]  rows,
  output logic             ok,
  output logic [MB_W-1:0]  x0,
  output logic [MB_W-1:0]  xe,
  output logic [MB_W-1:0]  y0,
  output logic [MB_W-1:0]  ye
);
  localparam int EW = PIX_W + 1;

  logic [EW-1:0] x_lim, y_lim, x_stop, y_stop;
  logic          geom_ok, flag_ok, qp_ok;
  logic signed [QP_IN_W-1:0] qv;

  always_comb begin
    x_lim  = EW'(rg.x) + EW'(rg.w);
    y_lim  = EW'(rg.y) + EW'(rg.h);
    x_stop = EW'(rg.x >> 4) + ((EW'(rg.w) + EW'(15)) >> 4);
    y_stop = EW'(rg.y >> 4) + ((EW'(rg.h) + EW'(15)) >> 4);
    x0     = MB_W'(rg.x >> 4);
    y0     = MB_W'(rg.y >> 4);
    xe     = (x_stop > EW'(cols)) ? cols : MB_W'(x_stop);
    ye     = (y_stop > EW'(rows)) ? rows : MB_W'(y_stop);

    geom_ok = (x_lim <= EW'(fw)) && (y_lim <= EW'(fh));
    flag_ok = (rg.intra <= FLAG_W'(1)) && (rg.mode <= FLAG_W'(1)) &&
              (rg.area < AREA_IN_W'(MAX_REGIONS));
    qv      = $signed(rg.qp);
    if (rg.mode == FLAG_W'(1))
      qp_ok = (qv >= 8'sd0) && (qv <= 8'sd51);
    else
      qp_ok = (qv >= -8'sd51) && (qv <= 8'sd51);
    ok = geom_ok && flag_ok && qp_ok;
  end
endmodule

// File: rtl/roi_map_ram.sv
module roi_map_ram #(
  parameter int WORD_W = 13,
  parameter int DEPTH  = 64,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/roi_map_gen.sv
module roi_map_gen
  import roi_map_pkg::*;
#(
  parameter int MAX_REGIONS = 8,
  parameter int MAX_MB_COLS = 8,
  parameter int MAX_MB_ROWS = 8,
  localparam int SLOT_W = $clog2(MAX_REGIONS),
  localparam int CNT_W  = $clog2(MAX_REGIONS + 1) + 1,
  localparam int DEPTH  = MAX_MB_COLS * MAX_MB_ROWS,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int WORD_W = $bits(map_word_t)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       ld_en,
  input  logic [SLOT_W-1:0]          ld_slot,
  input  logic [PIX_W-1:0]           ld_x,
  input  logic [PIX_W-1:0]           ld_y,
  input  logic [PIX_W-1:0]           ld_w,
  input  logic [PIX_W-1:0]           ld_h,
  input  logic [FLAG_W-1:0]          ld_intra,
  input  logic [FLAG_W-1:0]          ld_mode,
  input  logic [AREA_IN_W-1:0]       ld_area,
  input  logic signed [QP_IN_W-1:0]  ld_qp,
  input  logic                       start,
  input  logic signed [PIX_W-1:0]    frame_w,
  input  logic signed [PIX_W-1:0]    frame_h,
  input  logic [CNT_W-1:0]           region_cnt,
  input  logic [ADDR_W-1:0]          rd_addr,
  output logic [WORD_W-1:0]          rd_data,
  output logic                       busy,
  output logic                       done,
  output logic                       error
);
  localparam int MB_MAX = (MAX_MB_COLS > MAX_MB_ROWS) ? MAX_MB_COLS : MAX_MB_ROWS;
  localparam int MB_W   = $clog2(MB_MAX + 1);
  localparam int EW     = PIX_W + 1;
  localparam logic [PIX_W-1:0] CAP_W = PIX_W'(MAX_MB_COLS * 16);
  localparam logic [PIX_W-1:0] CAP_H = PIX_W'(MAX_MB_ROWS * 16);

  typedef enum logic [2:0] {S_IDLE, S_CLEAR, S_CHECK, S_SETUP, S_PAINT, S_FIN} state_t;
  state_t state;

  region_t           slots [MAX_REGIONS];
  logic [PIX_W-1:0]  fw_q, fh_q;
  logic [MB_W-1:0]   cols_q, rows_q, stride_q;
  logic [ADDR_W:0]   clear_end_q, ptr;
  logic [CNT_W-1:0]  cnt_q;
  logic [SLOT_W-1:0] ri;
  logic [MB_W-1:0]   x0_q, xe_q, ye_q, cx, cy;
  map_word_t         word_q, wr_word;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;

  // Frame geometry from the raw inputs, used only when start is taken.
  logic            size_bad, last_region, all_ok;
  logic [MB_W-1:0] cols_n, rows_n, stride_n, rpad_n;
  logic [ADDR_W:0] clear_end_n;

  always_comb begin
    size_bad = frame_w[PIX_W-1] || frame_h[PIX_W-1] || (frame_w == '0) ||
               (frame_h == '0) || ($unsigned(frame_w) > CAP_W) ||
               ($unsigned(frame_h) > CAP_H);
    cols_n      = MB_W'((EW'($unsigned(frame_w)) + EW'(15)) >> 4);
    rows_n      = MB_W'((EW'($unsigned(frame_h)) + EW'(15)) >> 4);
    stride_n    = (cols_n + MB_W'(3)) & ~MB_W'(3);
    rpad_n      = (rows_n + MB_W'(3)) & ~MB_W'(3);
    clear_end_n = (ADDR_W+1)'(stride_n) * (ADDR_W+1)'(rpad_n);
  end

  // One validator and bound calculator per slot.
  logic [MAX_REGIONS-1:0] slot_ok;
  logic [MB_W-1:0] g_x0 [MAX_REGIONS];
  logic [MB_W-1:0] g_xe [MAX_REGIONS];
  logic [MB_W-1:0] g_y0 [MAX_REGIONS];
  logic [MB_W-1:0] g_ye [MAX_REGIONS];

  for (genvar s = 0; s < MAX_REGIONS; s++) begin : g_slot
    roi_region_check #(.MAX_REGIONS(MAX_REGIONS), .MB_W(MB_W)) u_check (
      .rg(slots[s]), .fw(fw_q), .fh(fh_q), .cols(cols_q), .rows(rows_q),
      .ok(slot_ok[s]), .x0(g_x0[s]), .xe(g_xe[s]), .y0(g_y0[s]), .ye(g_ye[s])
    );
  end

  always_comb begin
    all_ok = 1'b1;
    for (int i = 0; i < MAX_REGIONS; i++)
      if (!slot_ok[i] && (CNT_W'(i) < cnt_q)) all_ok = 1'b0;
    last_region = (CNT_W'(ri) + CNT_W'(1)) == cnt_q;
  end

  always_ff @(posedge clk) begin
    if (ld_en && !busy)
      slots[ld_slot] <= '{x: ld_x, y: ld_y, w: ld_w, h: ld_h, intra: ld_intra,
                          mode: ld_mode, area: ld_area, qp: ld_qp};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      busy  <= 1'b0;
      done  <= 1'b0;
      error <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          busy        <= 1'b1;
          error       <= size_bad;
          done        <= size_bad;
          fw_q        <= $unsigned(frame_w);
          fh_q        <= $unsigned(frame_h);
          cols_q      <= cols_n;
          rows_q      <= rows_n;
          stride_q    <= stride_n;
          clear_end_q <= clear_end_n;
          cnt_q       <= region_cnt;
          ptr         <= '0;
          state       <= size_bad ? S_FIN : S_CLEAR;
        end
        S_CLEAR: begin
          ptr <= ptr + (ADDR_W+1)'(1);
          if (ptr == clear_end_q - (ADDR_W+1)'(1)) state <= S_CHECK;
        end
        S_CHECK: begin
          ri <= '0;
          if (cnt_q > CNT_W'(MAX_REGIONS) || !all_ok) begin
            error <= 1'b1;
            done  <= 1'b1;
            state <= S_FIN;
          end else if (cnt_q == '0) begin
            done  <= 1'b1;
            state <= S_FIN;
          end else begin
            state <= S_SETUP;
          end
        end
        S_SETUP: begin
          x0_q   <= g_x0[ri];
          xe_q   <= g_xe[ri];
          ye_q   <= g_ye[ri];
          cx     <= g_x0[ri];
          cy     <= g_y0[ri];
          word_q <= '{mode: slots[ri].mode[0], qp: slots[ri].qp[QP_W-1:0],
                      area_en: 1'b1, area_idx: slots[ri].area[AREA_IDX_W-1:0],
                      force_intra: slots[ri].intra[0]};
          if (g_x0[ri] >= g_xe[ri] || g_y0[ri] >= g_ye[ri]) begin
            if (last_region) begin
              done  <= 1'b1;
              state <= S_FIN;
            end else begin
              ri <= ri + SLOT_W'(1);
            end
          end else begin
            state <= S_PAINT;
          end
        end
        S_PAINT: begin
          if (cx == xe_q - MB_W'(1)) begin
            cx <= x0_q;
            if (cy == ye_q - MB_W'(1)) begin
              if (last_region) begin
                done  <= 1'b1;
                state <= S_FIN;
              end else begin
                ri    <= ri + SLOT_W'(1);
                state <= S_SETUP;
              end
            end else begin
              cy <= cy + MB_W'(1);
            end
          end else begin
            cx <= cx + MB_W'(1);
          end
        end
        S_FIN: begin
          busy  <= 1'b0;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    wr_en   = (state == S_CLEAR) || (state == S_PAINT);
    wr_addr = (state == S_CLEAR) ? ptr[ADDR_W-1:0]
                                 : ADDR_W'(cy) * ADDR_W'(stride_q) + ADDR_W'(cx);
    wr_word = (state == S_CLEAR) ? WORD_NEUTRAL : word_q;
  end

  roi_map_ram #(.WORD_W(WORD_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ram (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_word),
    .raddr(rd_addr), .rdata(rd_data)
  );
endmodule

// File: rtl/roi_map_chk.sv
module roi_map_chk
  import roi_map_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic              error,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input map_word_t         wr_word,
  input logic [ADDR_W:0]   clear_end
);
  p_done_single_r12: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_in_job_r12: assert property (@(posedge clk) disable iff (rst)
    done |-> busy);

  p_area_enable_r5: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> wr_word.area_en);

  p_write_in_area_r3: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ({1'b0, wr_addr} < clear_end));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !wr_en);

  p_error_with_done_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(error) |-> done);
endmodule

bind roi_map_gen roi_map_chk #(.ADDR_W(ADDR_W)) u_map_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .error(error),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_word(wr_word), .clear_end(clear_end_q)
);

// File: tb/roi_map_gen_test.sv
module roi_map_gen_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic               ld_en = 1'b0;
  logic [2:0]         ld_slot = '0;
  logic [11:0]        ld_x = '0, ld_y = '0, ld_w = '0, ld_h = '0;
  logic [1:0]         ld_intra = '0, ld_mode = '0;
  logic [3:0]         ld_area = '0;
  logic signed [7:0]  ld_qp = '0;
  logic               start = 1'b0;
  logic signed [11:0] frame_w = '0, frame_h = '0;
  logic [4:0]         region_cnt = '0;
  logic [5:0]         rd_addr = '0;
  logic [12:0]        rd_data;
  logic               busy, done, error;

  roi_map_gen uut (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_slot(ld_slot), .ld_x(ld_x),
    .ld_y(ld_y), .ld_w(ld_w), .ld_h(ld_h), .ld_intra(ld_intra),
    .ld_mode(ld_mode), .ld_area(ld_area), .ld_qp(ld_qp), .start(start),
    .frame_w(frame_w), .frame_h(frame_h), .region_cnt(region_cnt),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .done(done),
    .error(error)
  );

  int n_chk = 0;
  int n_fail = 0;
  int rx[8], ry[8], rw[8], rh[8], rfi[8], rmd[8], rar[8], rqp[8];
  int exp_mem[64];
  bit known[64];

  task automatic chk(input bit ok, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", what, act, expv);
    end
  endtask

  task automatic set_region(input int s, input int x, input int y, input int w,
                            input int h, input int fi, input int md,
                            input int ar, input int qp);
    rx[s] = x; ry[s] = y; rw[s] = w; rh[s] = h;
    rfi[s] = fi; rmd[s] = md; rar[s] = ar; rqp[s] = qp;
    @(negedge clk);
    ld_en = 1'b1; ld_slot = 3'(s); ld_x = 12'(x); ld_y = 12'(y);
    ld_w = 12'(w); ld_h = 12'(h); ld_intra = 2'(fi); ld_mode = 2'(md);
    ld_area = 4'(ar); ld_qp = 8'(qp);
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  function automatic bit region_legal(input int s, input int fw, input int fh);
    bit ok = 1'b1;
    if (rx[s] + rw[s] > fw || ry[s] + rh[s] > fh) ok = 1'b0;
    if (rfi[s] > 1 || rmd[s] > 1 || rar[s] >= 8) ok = 1'b0;
    if (rmd[s] == 1) begin
      if (rqp[s] < 0 || rqp[s] > 51) ok = 1'b0;
    end else if (rqp[s] < -51 || rqp[s] > 51) ok = 1'b0;
    return ok;
  endfunction

  task automatic check_map(input string tag);
    for (int a = 0; a < 64; a++) begin
      if (known[a]) begin
        rd_addr = 6'(a);
        @(negedge clk);
        chk(rd_data == 13'(exp_mem[a]), $sformatf("%s R2 map addr %0d", tag, a),
            int'(rd_data), exp_mem[a]);
      end
    end
  endtask

  task automatic run_frame(input int fw, input int fh, input int cnt, input string tag);
    int cols, rows, stride, rpad, lat, k;
    bit sbad, lbad;
    sbad = (fw <= 0) || (fh <= 0) || (fw > 128) || (fh > 128);
    lbad = 1'b0;
    lat  = 0;
    if (!sbad) begin
      cols = (fw + 15) / 16;  rows = (fh + 15) / 16;
      stride = ((cols + 3) / 4) * 4;  rpad = ((rows + 3) / 4) * 4;
      for (int a = 0; a < stride * rpad; a++) begin
        exp_mem[a] = 16;  known[a] = 1'b1;
      end
      lat = stride * rpad + 1;
      if (cnt > 8) lbad = 1'b1;
      for (int s = 0; s < cnt && s < 8; s++)
        if (!region_legal(s, fw, fh)) lbad = 1'b1;
      if (!lbad) begin
        for (int s = 0; s < cnt; s++) begin
          int x0, y0, xe, ye, word;
          x0 = rx[s] / 16;  y0 = ry[s] / 16;
          xe = x0 + (rw[s] + 15) / 16;  ye = y0 + (rh[s] + 15) / 16;
          if (xe > cols) xe = cols;
          if (ye > rows) ye = rows;
          word = ((rmd[s] & 1) << 12) | ((rqp[s] & 127) << 5) | 16 |
                 ((rar[s] & 7) << 1) | (rfi[s] & 1);
          lat += 1;
          for (int yy = y0; yy < ye; yy++)
            for (int xx = x0; xx < xe; xx++) begin
              exp_mem[yy * stride + xx] = word;
              lat += 1;
            end
        end
      end
    end
    @(negedge clk);
    frame_w = 12'(fw); frame_h = 12'(fh); region_cnt = 5'(cnt); start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    k = 1;
    while (!done && k < 4000) begin
      @(negedge clk);
      k++;
    end
    chk(done == 1'b1, {tag, " R12 done seen"}, int'(done), 1);
    chk(k == lat + 1, {tag, " R12 done latency"}, k, lat + 1);
    chk(error == (sbad || lbad), {tag, " error flag"}, int'(error), int'(sbad || lbad));
    @(negedge clk);
    chk(done == 1'b0, {tag, " R12 done one cycle"}, int'(done), 0);
    check_map(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int wl[6] = '{1, 16, 17, 40, 100, 128};
    int hl[4] = '{1, 31, 64, 128};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(done == 1'b0, "R1 done after reset", int'(done), 0);
    chk(error == 1'b0, "R1 error after reset", int'(error), 0);
    chk(busy == 1'b0, "R1 busy after reset", int'(busy), 0);

    // Sweep frame sizes with three overlapping regions (R2 R3 R4 R5 R6).
    foreach (wl[i]) begin
      foreach (hl[j]) begin
        int w = wl[i];
        int h = hl[j];
        set_region(0, 0, 0, w, h, 1, 0, 1, -5);
        set_region(1, w / 3, h / 4, w - w / 3, (h - h / 4) / 2, 0, 1, 7, 51);
        set_region(2, w / 2, h / 2, w - w / 2, h - h / 2, 1, 0, 3, -51);
        run_frame(w, h, 3, $sformatf("R4 R5 R6 sweep %0dx%0d", w, h));
      end
    end

    // Directed legality cases on a 40x24 frame.
    set_region(0, 0, 0, 40, 24, 1, 0, 2, 10);
    set_region(1, 17, 5, 10, 10, 0, 1, 6, 30);
    run_frame(40, 24, 2, "R6 base");
    set_region(1, 30, 0, 11, 8, 0, 0, 0, 0);
    run_frame(40, 24, 2, "R7 x+w over");
    run_frame(40, 24, 1, "R7 slot past count");
    set_region(1, 0, 20, 8, 5, 0, 0, 0, 0);
    run_frame(40, 24, 2, "R7 y+h over");
    set_region(1, 0, 0, 8, 8, 2, 0, 0, 0);
    run_frame(40, 24, 2, "R8 intra flag");
    set_region(1, 0, 0, 8, 8, 0, 2, 0, 0);
    run_frame(40, 24, 2, "R8 mode flag");
    set_region(1, 0, 0, 8, 8, 0, 0, 8, 0);
    run_frame(40, 24, 2, "R8 area index");
    set_region(1, 0, 0, 8, 8, 0, 1, 7, 52);
    run_frame(40, 24, 2, "R9 abs 52");
    set_region(1, 0, 0, 8, 8, 0, 1, 7, -1);
    run_frame(40, 24, 2, "R9 abs negative");
    set_region(1, 0, 0, 8, 8, 0, 0, 7, -52);
    run_frame(40, 24, 2, "R9 rel -52");
    set_region(1, 16, 16, 24, 8, 0, 1, 7, 51);
    run_frame(40, 24, 2, "R9 abs 51 legal");
    set_region(1, 16, 0, 20, 8, 0, 0, 5, -51);
    run_frame(40, 24, 2, "R9 rel -51 legal");
    for (int s = 2; s < 8; s++) set_region(s, s, s, 4, 4, 0, 0, s, s);
    run_frame(40, 24, 8, "R6 eight slots");
    run_frame(40, 24, 9, "R10 count nine");
    set_region(0, 16, 8, 0, 8, 1, 1, 4, 20);
    run_frame(40, 24, 1, "R4 empty region");

    // Frame size rejects keep the previous map untouched (R11).
    set_region(0, 8, 8, 20, 12, 1, 1, 5, 40);
    run_frame(40, 24, 1, "R4 before size tests");
    run_frame(0, 24, 1, "R11 zero width");
    run_frame(-16, 24, 1, "R11 negative width");
    run_frame(40, 0, 1, "R11 zero height");
    run_frame(129, 24, 1, "R11 width over cap");
    run_frame(40, 200, 1, "R11 height over cap");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule